// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block watches the write cycles that reach a parallel NOR flash and turns them into commands. A host unlocks the part by writing two fixed byte values at two fixed offsets. It then names an operation: a byte program, an erase, an identifier read, entry to a fast-program mode, or a reset. The sequencer tracks where the host is in each multi-cycle sequence. It reports which data source the read path should present (array, status, identifier or query table). It hands program and erase requests, with their address and data, to the array and timing logic.

A separate query mode can be entered in two ways: in one write from plain array reads, or from inside identifier mode. In the second case a reset returns to identifier mode. In unlock-bypass mode the unlock cycles are skipped, so a program takes two writes. After each operation in that mode the sequencer returns to the bypass command state and not to plain array reads. The array, the erase timer and the table contents sit outside this block. A done input from the timing logic ends every program or erase.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, mode_o is 0 (array), cmd_o is 0x00, bypass_o is 0, and prog_req_o and erase_req_o are low.
- R2: An unlock is data 0xAA at offset 0x555 followed by data 0x55 at offset 0x2AA. Only address bits [10:0] are compared. Any other write in the second unlock cycle returns to array read.
- R3: Unlock then 0xA0 at 0x555 arms a program. The next write raises prog_req_o for exactly one cycle, carrying that write's address and data. mode_o is then 1 (status) and cmd_o is 0xA0 until done_i.
- R4: While a program is busy, every write is ignored, 0xF0 included. done_i returns to the idle command state.
- R5: Unlock then 0x90 at 0x555 gives mode_o 2 (ID) with cmd_o 0x90. In that mode, 0xF0 or any byte other than 0x98 or a bypass exit returns to array read.
- R6: In plain array state, 0x98 written at offset 0x055 gives mode_o 3 (query) with cmd_o 0x98. At any other offset it has no effect. In query mode every write except 0xF0 is ignored, and 0xF0 returns to array read.
- R7: In ID mode, 0x98 at any offset enters query mode. A 0xF0 from there returns to ID mode (mode_o 2), and a further 0xF0 returns to array read.
- R8: Unlock, 0x80, 0xAA at 0x555 and 0x55 at 0x2AA arm an erase. Then 0x10 at 0x555 pulses erase_req_o with erase_chip_o 1 (every location becomes 0xFF) and cmd_o 0x10. Instead, 0x30 at any address pulses erase_req_o with erase_chip_o 0, erase_addr_o set to that address, and cmd_o 0x30. 0x10 at any other offset aborts without a request.
- R9: While an erase is busy (mode_o 1), 0xF0 and every other write are ignored until done_i.
- R10: Unlock then 0x20 sets bypass_o. In bypass, the command cycle has no address check. 0xA0 followed by one write programs, and after done_i the sequencer returns to the bypass command state with bypass_o still 1.
- R11: In bypass, 0x90 gives ID mode with bypass_o kept. A following 0x00 clears bypass_o and returns to array read.
- R12: An unknown command byte aborts to array read, or to the bypass command state when bypass is active. Outside the program data cycle and the busy states, 0xF0 returns to array read and clears bypass_o.
- R13: cmd_o is 0xA0 while programming, 0x80 during erase setup, 0x10 or 0x30 during chip or sector erase, 0x90 in ID mode, 0x98 in either query mode, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | AW | Write address |
| data_i | input | 8 | Write data byte |
| done_i | input | 1 | Program or erase finished |
| mode_o | output | 2 | Read source: 0 array, 1 status, 2 ID, 3 query |
| cmd_o | output | 8 | Command in progress |
| bypass_o | output | 1 | Unlock-bypass active |
| prog_req_o | output | 1 | One-cycle program request |
| prog_addr_o | output | AW | Program address |
| prog_data_o | output | 8 | Program data |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_chip_o | output | 1 | 1 for a whole-chip erase, 0 for a sector |
| erase_addr_o | output | AW | Address inside the sector to erase |

## Verification
The busy-state properties take for granted that done_i is raised only while an operation is busy. They also assume that done_i is never asserted in the same cycle a request issues. The stimulus keeps to this by pulsing done_i only after the bench has seen mode_o read status. Write strobes are single-cycle and spaced apart, so each command cycle is one clean write. A behavioural model in the bench tracks every clock and is compared with all outputs.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_CMD, ST_PROG, ST_ERS_A, ST_ERS_B, ST_ERS_C,
    ST_BUSY_PROG, ST_BUSY_ERS, ST_ID, ST_CFI, ST_ID_CFI
  } seq_state_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_STATUS = 2'd1;
  localparam logic [1:0] RM_ID     = 2'd2;
  localparam logic [1:0] RM_CFI    = 2'd3;

  localparam logic [7:0] C_KEY_A   = 8'hAA;
  localparam logic [7:0] C_KEY_B   = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_AUTOSEL = 8'h90;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECTOR  = 8'h30;
  localparam logic [7:0] C_EXIT    = 8'h00;
endpackage

// File: rtl/nor_seq_match.sv
module nor_seq_match #(
  parameter int              UW       = 11,
  parameter logic [UW-1:0]   KEY_ADDR = '0,
  parameter logic [7:0]      KEY_DATA = 8'h00
) (
  input  logic [UW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          hit_o
);
  assign hit_o = (addr_i == KEY_ADDR) && (data_i == KEY_DATA);
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       byp_i,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  input  logic       a0_i,      // address equals first unlock offset
  input  logic       key0_i,    // first unlock cycle matched
  input  logic       key1_i,    // second unlock cycle matched
  input  logic       qry_i,     // address equals query offset
  input  logic       done_i,
  output seq_state_e next_o,
  output logic       byp_next_o,
  output logic       prog_go_o,
  output logic       erase_go_o,
  output logic       chip_go_o
);
  seq_state_e home;

  always_comb begin
    next_o     = state_i;
    byp_next_o = byp_i;
    prog_go_o  = 1'b0;
    erase_go_o = 1'b0;
    chip_go_o  = 1'b0;
    home       = byp_i ? ST_CMD : ST_IDLE;
    if (state_i == ST_BUSY_PROG || state_i == ST_BUSY_ERS) begin
      if (done_i) next_o = home;
    end else if (wr_i) begin
      if (data_i == C_RESET && state_i != ST_PROG) begin
        if (state_i == ST_ID_CFI) next_o = ST_ID;
        else begin
          next_o     = ST_IDLE;
          byp_next_o = 1'b0;
        end
      end else begin
        case (state_i)
          ST_IDLE: begin
            if (key0_i) next_o = ST_UNL1;
            else if (qry_i && data_i == C_QUERY) next_o = ST_CFI;
          end
          ST_UNL1: next_o = key1_i ? ST_CMD : ST_IDLE;
          ST_CMD: begin
            if (!byp_i && !a0_i) next_o = ST_IDLE;
            else begin
              case (data_i)
                C_PROG:    next_o = ST_PROG;
                C_ERASE:   next_o = ST_ERS_A;
                C_AUTOSEL: next_o = ST_ID;
                C_BYPASS: begin
                  byp_next_o = 1'b1;
                  next_o     = ST_CMD;
                end
                default:   next_o = home;
              endcase
            end
          end
          ST_PROG: begin
            prog_go_o = 1'b1;
            next_o    = ST_BUSY_PROG;
          end
          ST_ERS_A: next_o = key0_i ? ST_ERS_B : home;
          ST_ERS_B: next_o = key1_i ? ST_ERS_C : home;
          ST_ERS_C: begin
            if (data_i == C_CHIP && a0_i) begin
              erase_go_o = 1'b1;
              chip_go_o  = 1'b1;
              next_o     = ST_BUSY_ERS;
            end else if (data_i == C_SECTOR) begin
              erase_go_o = 1'b1;
              next_o     = ST_BUSY_ERS;
            end else next_o = home;
          end
          ST_ID: begin
            if (byp_i && data_i == C_EXIT) begin
              byp_next_o = 1'b0;
              next_o     = ST_IDLE;
            end else if (data_i == C_QUERY) next_o = ST_ID_CFI;
            else next_o = home;
          end
          default: ;  // query modes hold on invalid writes
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_seq_req.sv
module nor_seq_req #(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_go_i,
  input  logic          erase_go_i,
  input  logic          chip_go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          prog_req_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o,
  output logic          erase_req_o,
  output logic          erase_chip_o,
  output logic [AW-1:0] erase_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o   <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      erase_req_o  <= 1'b0;
      erase_chip_o <= 1'b0;
      erase_addr_o <= '0;
    end else begin
      prog_req_o  <= prog_go_i;
      erase_req_o <= erase_go_i;
      if (prog_go_i) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
      end
      if (erase_go_i) begin
        erase_chip_o <= chip_go_i;
        erase_addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int           AW      = 20,
  parameter int           CMP_W   = 11,
  parameter logic [10:0]  UNLK0   = 11'h555,
  parameter logic [10:0]  UNLK1   = 11'h2AA,
  parameter logic [10:0]  QRY_OFS = 11'h055
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          done_i,
  output logic [1:0]    mode_o,
  output logic [7:0]    cmd_o,
  output logic          bypass_o,
  output logic          prog_req_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o,
  output logic          erase_req_o,
  output logic          erase_chip_o,
  output logic [AW-1:0] erase_addr_o
);
  localparam int NKEY = 2;
  localparam logic [CMP_W-1:0] KEY_A [NKEY] = '{CMP_W'(UNLK0), CMP_W'(UNLK1)};
  localparam logic [7:0]       KEY_D [NKEY] = '{C_KEY_A, C_KEY_B};

  seq_state_e       state_q, state_d;
  logic             byp_q, byp_d;
  logic [NKEY-1:0]  key_hit;
  logic [CMP_W-1:0] addr_lo;
  logic             prog_go, erase_go, chip_go;

  assign addr_lo = addr_i[CMP_W-1:0];

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    nor_seq_match #(.UW(CMP_W), .KEY_ADDR(KEY_A[k]), .KEY_DATA(KEY_D[k])) u_match (
      .addr_i(addr_lo), .data_i(data_i), .hit_o(key_hit[k])
    );
  end

  nor_seq_fsm u_fsm (
    .state_i(state_q), .byp_i(byp_q), .wr_i(wr_i), .data_i(data_i),
    .a0_i(addr_lo == CMP_W'(UNLK0)), .key0_i(key_hit[0]), .key1_i(key_hit[1]),
    .qry_i(addr_lo == CMP_W'(QRY_OFS)), .done_i(done_i),
    .next_o(state_d), .byp_next_o(byp_d),
    .prog_go_o(prog_go), .erase_go_o(erase_go), .chip_go_o(chip_go)
  );

  nor_seq_req #(.AW(AW)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_go_i(prog_go), .erase_go_i(erase_go),
    .chip_go_i(chip_go), .addr_i(addr_i), .data_i(data_i),
    .prog_req_o(prog_req_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
    .erase_req_o(erase_req_o), .erase_chip_o(erase_chip_o), .erase_addr_o(erase_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
    end
  end

  assign bypass_o = byp_q;

  always_comb begin
    case (state_q)
      ST_BUSY_PROG, ST_BUSY_ERS: mode_o = RM_STATUS;
      ST_ID:                     mode_o = RM_ID;
      ST_CFI, ST_ID_CFI:         mode_o = RM_CFI;
      default:                   mode_o = RM_ARRAY;
    endcase
    case (state_q)
      ST_PROG, ST_BUSY_PROG:       cmd_o = C_PROG;
      ST_ERS_A, ST_ERS_B, ST_ERS_C: cmd_o = C_ERASE;
      ST_BUSY_ERS:                 cmd_o = erase_chip_o ? C_CHIP : C_SECTOR;
      ST_ID:                       cmd_o = C_AUTOSEL;
      ST_CFI, ST_ID_CFI:           cmd_o = C_QUERY;
      default:                     cmd_o = C_EXIT;
    endcase
  end
endmodule

// File: rtl/nor_cmd_seq_sva.sv
module nor_cmd_seq_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [7:0] data_i,
  input logic       done_i,
  input logic [1:0] mode_o,
  input logic [7:0] cmd_o,
  input logic       bypass_o,
  input logic       prog_req_o,
  input logic       erase_req_o
);
  assert_prog_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);

  assert_prog_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (mode_o == 2'd1 && cmd_o == 8'hA0));

  assert_prog_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && cmd_o == 8'hA0 && !done_i) |=>
      (mode_o == 2'd1 && cmd_o == 8'hA0 && !prog_req_o));

  assert_erase_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && cmd_o != 8'hA0 && !done_i) |=>
      (mode_o == 2'd1 && $stable(cmd_o) && !erase_req_o));

  assert_query_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !(wr_i && data_i == 8'hF0)) |=> mode_o == 2'd3);

  assert_bypass_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bypass_o));

  assert_single_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, erase_req_o}));
endmodule

bind nor_cmd_seq nor_cmd_seq_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .data_i(data_i), .done_i(done_i),
  .mode_o(mode_o), .cmd_o(cmd_o), .bypass_o(bypass_o),
  .prog_req_o(prog_req_o), .erase_req_o(erase_req_o)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr;
  logic [AW-1:0] addr;
  logic [7:0]    data;
  logic          done;
  logic [1:0]    mode_o;
  logic [7:0]    cmd_o;
  logic          bypass_o, prog_req_o, erase_req_o, erase_chip_o;
  logic [AW-1:0] prog_addr_o, erase_addr_o;
  logic [7:0]    prog_data_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data), .done_i(done),
    .mode_o(mode_o), .cmd_o(cmd_o), .bypass_o(bypass_o),
    .prog_req_o(prog_req_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
    .erase_req_o(erase_req_o), .erase_chip_o(erase_chip_o), .erase_addr_o(erase_addr_o)
  );

  // Behavioural reference: phase numbers 0 idle,1 second key,2 command,3 program data,
  // 4..6 erase cycles,7 program busy,8 erase busy,9 ID,10 query,11 query from ID
  int            m_ph;
  bit            m_byp, m_chip, m_preq, m_ereq;
  logic [AW-1:0] m_paddr, m_eaddr;
  logic [7:0]    m_pdata;
  logic [10:0]   lo;
  int            hm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_byp = 0; m_chip = 0; m_preq = 0; m_ereq = 0;
      m_paddr = '0; m_eaddr = '0; m_pdata = '0;
    end else begin
      m_preq = 0; m_ereq = 0;
      lo = addr[10:0];
      hm = m_byp ? 2 : 0;
      if (m_ph == 7 || m_ph == 8) begin
        if (done) m_ph = hm;
      end else if (wr) begin
        if (data == 8'hF0 && m_ph != 3) begin
          if (m_ph == 11) m_ph = 9;
          else begin m_ph = 0; m_byp = 0; end
        end else begin
          case (m_ph)
            0: if (lo == 11'h555 && data == 8'hAA) m_ph = 1;
               else if (lo == 11'h055 && data == 8'h98) m_ph = 10;
            1: m_ph = (lo == 11'h2AA && data == 8'h55) ? 2 : 0;
            2: if (!m_byp && lo != 11'h555) m_ph = 0;
               else if (data == 8'hA0) m_ph = 3;
               else if (data == 8'h80) m_ph = 4;
               else if (data == 8'h90) m_ph = 9;
               else if (data == 8'h20) begin m_byp = 1; m_ph = 2; end
               else m_ph = hm;
            3: begin m_preq = 1; m_paddr = addr; m_pdata = data; m_ph = 7; end
            4: m_ph = (lo == 11'h555 && data == 8'hAA) ? 5 : hm;
            5: m_ph = (lo == 11'h2AA && data == 8'h55) ? 6 : hm;
            6: if (data == 8'h10 && lo == 11'h555) begin
                 m_ereq = 1; m_chip = 1; m_eaddr = addr; m_ph = 8;
               end else if (data == 8'h30) begin
                 m_ereq = 1; m_chip = 0; m_eaddr = addr; m_ph = 8;
               end else m_ph = hm;
            9: if (m_byp && data == 8'h00) begin m_byp = 0; m_ph = 0; end
               else if (data == 8'h98) m_ph = 11;
               else m_ph = hm;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic int exp_mode(int ph);
    case (ph)
      7, 8:   return 1;
      9:      return 2;
      10, 11: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_cmd(int ph, bit chip);
    case (ph)
      3, 7:    return 32'hA0;
      4, 5, 6: return 32'h80;
      8:       return chip ? 32'h10 : 32'h30;
      9:       return 32'h90;
      10, 11:  return 32'h98;
      default: return 32'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, tagged with the scenario's requirement
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " model mode"}, 32'(mode_o), exp_mode(m_ph));
      chk({cur_req, " model cmd"}, 32'(cmd_o), exp_cmd(m_ph, m_chip));
      chk({cur_req, " model bypass"}, 32'(bypass_o), 32'(m_byp));
      chk({cur_req, " model prog_req"}, 32'(prog_req_o), 32'(m_preq));
      chk({cur_req, " model erase_req"}, 32'(erase_req_o), 32'(m_ereq));
      if (m_preq) begin
        chk({cur_req, " model prog_addr"}, 32'(prog_addr_o), 32'(m_paddr));
        chk({cur_req, " model prog_data"}, 32'(prog_data_o), 32'(m_pdata));
      end
      if (m_ereq) begin
        chk({cur_req, " model erase_addr"}, 32'(erase_addr_o), 32'(m_eaddr));
        chk({cur_req, " model erase_chip"}, 32'(erase_chip_o), 32'(m_chip));
      end
    end
  end

  task automatic wr_cyc(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic unlock();
    wr_cyc(20'h00555, 8'hAA);
    wr_cyc(20'h002AA, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = '0; data = '0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 cmd", 32'(cmd_o), 0);
    chk("R1 bypass", 32'(bypass_o), 0);
    chk("R1 reqs", 32'({prog_req_o, erase_req_o}), 0);

    // unlock with upper address bits set, then ID
    cur_req = "R2";
    wr_cyc(20'hFF555, 8'hAA);
    wr_cyc(20'h7A2AA, 8'h55);
    wr_cyc(20'h00555, 8'h90);
    chk("R2 masked unlock reaches ID", 32'(mode_o), 2);
    chk("R5 cmd in ID", 32'(cmd_o), 32'h90);
    wr_cyc(20'h0, 8'hF0);
    chk("R5 reset from ID", 32'(mode_o), 0);

    // bad second key
    wr_cyc(20'h00555, 8'hAA);
    wr_cyc(20'h002AA, 8'h56);
    wr_cyc(20'h00555, 8'h90);
    chk("R2 mismatch aborts", 32'(mode_o), 0);

    cur_req = "R5";
    unlock();
    wr_cyc(20'h00555, 8'h90);
    wr_cyc(20'h00100, 8'h42);
    chk("R5 other byte leaves ID", 32'(mode_o), 0);

    // program
    cur_req = "R3";
    unlock();
    wr_cyc(20'h00555, 8'hA0);
    chk("R13 cmd program armed", 32'(cmd_o), 32'hA0);
    wr_cyc(20'h12345, 8'h3C);
    chk("R3 prog_req", 32'(prog_req_o), 1);
    chk("R3 prog_addr", 32'(prog_addr_o), 32'h12345);
    chk("R3 prog_data", 32'(prog_data_o), 32'h3C);
    chk("R3 status mode", 32'(mode_o), 1);
    cur_req = "R4";
    wr_cyc(20'h0, 8'hF0);
    wr_cyc(20'h00555, 8'hAA);
    chk("R4 writes ignored while busy", 32'(mode_o), 1);
    chk("R4 no new request", 32'(prog_req_o), 0);
    pulse_done();
    chk("R4 done returns to array", 32'(mode_o), 0);

    // direct query entry
    cur_req = "R6";
    wr_cyc(20'h00056, 8'h98);
    chk("R6 wrong offset ignored", 32'(mode_o), 0);
    wr_cyc(20'h30055, 8'h98);
    chk("R6 query entry", 32'(mode_o), 3);
    wr_cyc(20'h00000, 8'h12);
    chk("R6 invalid write keeps query", 32'(mode_o), 3);
    wr_cyc(20'h0, 8'hF0);
    chk("R6 reset from query", 32'(mode_o), 0);

    // query from ID
    cur_req = "R7";
    unlock();
    wr_cyc(20'h00555, 8'h90);
    wr_cyc(20'h00ABC, 8'h98);
    chk("R7 query from ID", 32'(mode_o), 3);
    wr_cyc(20'h0, 8'hF0);
    chk("R7 reset back to ID", 32'(mode_o), 2);
    wr_cyc(20'h0, 8'hF0);
    chk("R7 second reset to array", 32'(mode_o), 0);

    // chip erase
    cur_req = "R8";
    unlock();
    wr_cyc(20'h00555, 8'h80);
    chk("R13 cmd erase setup", 32'(cmd_o), 32'h80);
    unlock();
    wr_cyc(20'h00555, 8'h10);
    chk("R8 chip erase req", 32'(erase_req_o), 1);
    chk("R8 chip flag", 32'(erase_chip_o), 1);
    chk("R13 cmd chip", 32'(cmd_o), 32'h10);
    cur_req = "R9";
    wr_cyc(20'h0, 8'hF0);
    chk("R9 reset ignored in erase", 32'(mode_o), 1);
    chk("R9 cmd held", 32'(cmd_o), 32'h10);
    pulse_done();
    chk("R9 done ends erase", 32'(mode_o), 0);

    // sector erase at arbitrary address
    cur_req = "R8";
    unlock();
    wr_cyc(20'h00555, 8'h80);
    unlock();
    wr_cyc(20'h41000, 8'h30);
    chk("R8 sector req", 32'(erase_req_o), 1);
    chk("R8 sector addr", 32'(erase_addr_o), 32'h41000);
    chk("R8 sector flag", 32'(erase_chip_o), 0);
    chk("R13 cmd sector", 32'(cmd_o), 32'h30);
    pulse_done();

    // chip erase at wrong offset aborts
    unlock();
    wr_cyc(20'h00555, 8'h80);
    unlock();
    wr_cyc(20'h00123, 8'h10);
    chk("R8 misplaced chip erase aborts", 32'(mode_o), 0);
    chk("R8 misplaced chip erase cmd", 32'(cmd_o), 0);

    // bypass
    cur_req = "R10";
    unlock();
    wr_cyc(20'h00555, 8'h20);
    chk("R10 bypass set", 32'(bypass_o), 1);
    wr_cyc(20'h00777, 8'hA0);
    chk("R10 short program armed", 32'(cmd_o), 32'hA0);
    wr_cyc(20'h00010, 8'hA5);
    chk("R10 prog_req", 32'(prog_req_o), 1);
    chk("R10 prog_data", 32'(prog_data_o), 32'hA5);
    pulse_done();
    chk("R10 bypass kept", 32'(bypass_o), 1);
    chk("R10 back to command state", 32'(cmd_o), 0);

    cur_req = "R12";
    wr_cyc(20'h00000, 8'h77);
    chk("R12 unknown byte keeps bypass", 32'(bypass_o), 1);
    wr_cyc(20'h00001, 8'hA0);
    chk("R12 still in bypass command state", 32'(cmd_o), 32'hA0);
    wr_cyc(20'h00020, 8'h5A);
    pulse_done();

    cur_req = "R11";
    wr_cyc(20'h00000, 8'h90);
    chk("R11 ID in bypass", 32'(mode_o), 2);
    chk("R11 bypass held in ID", 32'(bypass_o), 1);
    wr_cyc(20'h00000, 8'h00);
    chk("R11 exit clears bypass", 32'(bypass_o), 0);
    chk("R11 exit to array", 32'(mode_o), 0);

    cur_req = "R12";
    unlock();
    wr_cyc(20'h00555, 8'h33);
    chk("R12 unknown command aborts", 32'(cmd_o), 0);
    wr_cyc(20'h00555, 8'h90);
    chk("R12 after abort no ID", 32'(mode_o), 0);
    unlock();
    wr_cyc(20'h00555, 8'h20);
    wr_cyc(20'h00000, 8'hF0);
    chk("R12 reset clears bypass", 32'(bypass_o), 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule